// File: doc/BRIEF.md
# Two-Stage Serial Bit Clock Divider

This block derives the bit clock of a synchronous serial master from the system clock. Each direction, transmit and receive, has its own 16-bit clock-select register. The register holds a prescale value from 1 to 32 and a ratio code that picks a power-of-two stage from 1 to 32. The total division is the prescale times the ratio, so a bit period lasts between 2 and 1024 system cycles. When the receive side is told to follow the transmit side, the receive register is ignored and both directions run from the transmit setting.

Each direction drives a registered serial clock with a selectable idle level. It also drives two single-cycle strobes for the transfer engine: a shift strobe at the launch edge and a sample strobe at the capture edge. The clock runs only while the clock-enable input is high. A forbidden setting, ratio 1 combined with a prescale above 2, falls back to ratio 2 and raises a sticky error flag.

Top module: `serclk_divider`

## Requirements
- R1: After reset, both serial clocks sit at the level of `cpol`, all strobes and `cfg_err` are low, and both registers decode to a total divisor of 2.
- R2: In a clock-select word, bits [12:8] hold the prescale minus one and bits [2:0] hold the ratio code. All other bits are ignored.
- R3: Ratio codes 0, 1, 2, 3 and 4 select 2, 4, 8, 16 and 32. A period lasts N = prescale × ratio cycles. The clock is at the active level (the inverse of `cpol`) for the first N/2 cycles of each period and at the idle level for the rest.
- R4: Codes 5 and 6 are reserved and divide like code 4 (ratio 32).
- R5: Code 7 selects ratio 1 when the prescale is 1 or 2, and leaves `cfg_err` untouched. A resulting total of 1 is raised to 2.
- R6: A write of code 7 with a prescale above 2 uses ratio 2 instead and sets `cfg_err`.
- R7: `cfg_err` stays set until reset, including across later legal writes.
- R8: In the cycle after `clk_en` is sampled low, the clock is at the `cpol` level, both strobes are low and the divider restarts. The first leading edge comes one cycle after `clk_en` is sampled high.
- R9: Every clock edge carries exactly one strobe, and no cycle carries both. The leading edge is the idle-to-active transition. With `cpha`=0 the sample strobe marks the leading edge and the shift strobe the trailing edge. With `cpha`=1 the two are swapped.
- R10: A write with `cfg_sel`=0 goes to the transmit register and `cfg_sel`=1 to the receive register. With `rx_follow_tx`=1 the receive outputs use the transmit register.
- R11: Prescale 32 with code 4 gives the largest divisor, 1024 cycles per period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Register select: 0 transmit, 1 receive |
| cfg_wdata | input | 16 | Clock-select word to write |
| rx_follow_tx | input | 1 | Receive side uses the transmit setting |
| clk_en | input | 1 | Serial clock run enable |
| cpol | input | 1 | Idle level of the serial clocks |
| cpha | input | 1 | Edge selection for the launch and capture strobes |
| tx_sck | output | 1 | Transmit serial clock |
| tx_shift | output | 1 | Transmit launch-edge strobe |
| tx_sample | output | 1 | Transmit capture-edge strobe |
| rx_sck | output | 1 | Receive serial clock |
| rx_shift | output | 1 | Receive launch-edge strobe |
| rx_sample | output | 1 | Receive capture-edge strobe |
| cfg_err | output | 1 | Sticky flag for a forbidden ratio/prescale setting |

## Verification
The bench predicts every output bit of both directions in every cycle of each enabled window, so a divider that is off by one cycle or has an uneven duty shows up at once. Corner settings get their own runs:
- Reserved codes: a design that decoded 5 or 6 as anything other than 32 would give the wrong period.
- The legal and illegal ratio-1 settings: a design that did not fall back would clock at the prescale rate instead of twice it.
- The clamp of a total of 1 to 2: a design without it would stall or drive a constant level.
- The 1024-cycle maximum: a counter that is one bit too narrow would wrap early.

Separate runs check that the error flag stays set after a legal write, that bits outside the two fields are ignored, and that the follow mode ignores a different receive setting. A design that failed any of these would show it as a mismatched period or a wrong flag value.

// File: rtl/serclk_pkg.sv
package serclk_pkg;

    localparam int CSR_W     = 16;
    localparam int PRE_W     = 5;
    localparam int PRE_LSB   = 8;
    localparam int CODE_W    = 3;
    localparam int MAX_SHIFT = 5;
    localparam int DIV_W     = PRE_W + MAX_SHIFT + 1;
    localparam int NUM_CH    = 2;

    typedef enum logic [CODE_W-1:0] {
        RATIO_2    = 3'd0,
        RATIO_4    = 3'd1,
        RATIO_8    = 3'd2,
        RATIO_16   = 3'd3,
        RATIO_32   = 3'd4,
        RATIO_RSV5 = 3'd5,
        RATIO_RSV6 = 3'd6,
        RATIO_1    = 3'd7
    } ratio_code_e;

    typedef struct packed {
        logic [PRE_W-1:0] pre_m1;
        ratio_code_e      code;
    } clksel_t;

    typedef struct packed {
        logic [DIV_W-1:0] total;
        logic             bad_combo;
    } div_cfg_t;

    function automatic clksel_t unpack_csr(input logic [CSR_W-1:0] w);
        clksel_t s;
        s.pre_m1 = w[PRE_LSB +: PRE_W];
        s.code   = ratio_code_e'(w[CODE_W-1:0]);
        return s;
    endfunction

    // Prescale times ratio; reserved codes act as 32, forbidden ratio 1 as 2.
    function automatic div_cfg_t resolve_div(input clksel_t s);
        div_cfg_t         r;
        logic [2:0]       sh;
        logic [DIV_W-1:0] pre;
        pre = DIV_W'(s.pre_m1) + DIV_W'(1);
        r.bad_combo = 1'b0;
        case (s.code)
            RATIO_2:  sh = 3'd1;
            RATIO_4:  sh = 3'd2;
            RATIO_8:  sh = 3'd3;
            RATIO_16: sh = 3'd4;
            RATIO_1: begin
                if (s.pre_m1 > PRE_W'(1)) begin
                    r.bad_combo = 1'b1;
                    sh = 3'd1;
                end else begin
                    sh = 3'd0;
                end
            end
            default:  sh = 3'd5;
        endcase
        r.total = pre << sh;
        if (r.total < DIV_W'(2)) begin
            r.total = DIV_W'(2);
        end
        return r;
    endfunction

endpackage

// File: rtl/serclk_cfg.sv
module serclk_cfg
    import serclk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic             sel,
    input  logic [CSR_W-1:0] wdata,
    input  logic             rx_follow,
    output logic [DIV_W-1:0] tx_div,
    output logic [DIV_W-1:0] rx_div,
    output logic             cfg_err
);

    clksel_t  tx_q, rx_q;
    div_cfg_t tx_res, rx_res, wr_res;
    logic     err_q, seen_q;

    assign wr_res = resolve_div(unpack_csr(wdata));
    assign tx_res = resolve_div(tx_q);
    assign rx_res = resolve_div(rx_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q   <= '{pre_m1: '0, code: RATIO_2};
            rx_q   <= '{pre_m1: '0, code: RATIO_2};
            err_q  <= 1'b0;
            seen_q <= 1'b0;
        end else begin
            seen_q <= 1'b1;
            if (we) begin
                if (sel) rx_q <= unpack_csr(wdata);
                else     tx_q <= unpack_csr(wdata);
                if (wr_res.bad_combo) err_q <= 1'b1;
            end
        end
    end

    assign tx_div  = tx_res.total;
    assign rx_div  = rx_follow ? tx_res.total : rx_res.total;
    assign cfg_err = err_q;

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (seen_q && $past(cfg_err)) |-> cfg_err); // R7

    AST_DIV_RANGE: assert property (@(posedge clk) disable iff (rst)
        (tx_div >= DIV_W'(2)) && (tx_div <= (DIV_W'(1) << (PRE_W + MAX_SHIFT)))); // R11

    AST_RATIO_FALLBACK: assert property (@(posedge clk) disable iff (rst)
        (seen_q && $past(we && !sel && (wdata[CODE_W-1:0] == 3'd7)
                         && (wdata[PRE_LSB +: PRE_W] > 5'd1)))
        |-> (tx_div == ((DIV_W'($past(wdata[PRE_LSB +: PRE_W])) + DIV_W'(1)) << 1)) && cfg_err); // R6

endmodule

// File: rtl/serclk_edge_gen.sv
module serclk_edge_gen #(
    parameter int DIV_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             cpol,
    input  logic             cpha,
    input  logic [DIV_W-1:0] divisor,
    output logic             sck,
    output logic             shift_stb,
    output logic             sample_stb
);

    logic [DIV_W-1:0] cnt_q, half;
    logic             sck_q, lead_q, trail_q, seen_q;

    assign half = divisor >> 1;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            sck_q   <= cpol;
            lead_q  <= 1'b0;
            trail_q <= 1'b0;
            seen_q  <= 1'b0;
        end else begin
            seen_q <= 1'b1;
            if (!en) begin
                cnt_q   <= '0;
                sck_q   <= cpol;
                lead_q  <= 1'b0;
                trail_q <= 1'b0;
            end else begin
                lead_q  <= (cnt_q == '0);
                trail_q <= (cnt_q == half);
                if (cnt_q == '0)       sck_q <= ~cpol;
                else if (cnt_q == half) sck_q <= cpol;
                cnt_q <= (cnt_q >= divisor - 1'b1) ? '0 : cnt_q + 1'b1;
            end
        end
    end

    assign sck        = sck_q;
    assign shift_stb  = cpha ? lead_q  : trail_q;
    assign sample_stb = cpha ? trail_q : lead_q;

    AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        (seen_q && !$past(en)) |-> (sck == $past(cpol)) && !shift_stb && !sample_stb); // R8

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        $onehot0({shift_stb, sample_stb})); // R9

    AST_EDGE_MARKED: assert property (@(posedge clk) disable iff (rst)
        (seen_q && $past(en) && (sck != $past(sck)))
        |-> ($countones({shift_stb, sample_stb}) == 1)); // R9

endmodule

// File: rtl/serclk_divider.sv
module serclk_divider
    import serclk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic             cfg_sel,
    input  logic [CSR_W-1:0] cfg_wdata,
    input  logic             rx_follow_tx,
    input  logic             clk_en,
    input  logic             cpol,
    input  logic             cpha,
    output logic             tx_sck,
    output logic             tx_shift,
    output logic             tx_sample,
    output logic             rx_sck,
    output logic             rx_shift,
    output logic             rx_sample,
    output logic             cfg_err
);

    logic [DIV_W-1:0]  div_ch [NUM_CH];
    logic [NUM_CH-1:0] sck_v, shift_v, sample_v;

    serclk_cfg u_cfg (
        .clk       (clk),
        .rst       (rst),
        .we        (cfg_we),
        .sel       (cfg_sel),
        .wdata     (cfg_wdata),
        .rx_follow (rx_follow_tx),
        .tx_div    (div_ch[0]),
        .rx_div    (div_ch[1]),
        .cfg_err   (cfg_err)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        serclk_edge_gen #(.DIV_W(DIV_W)) u_gen (
            .clk        (clk),
            .rst        (rst),
            .en         (clk_en),
            .cpol       (cpol),
            .cpha       (cpha),
            .divisor    (div_ch[g]),
            .sck        (sck_v[g]),
            .shift_stb  (shift_v[g]),
            .sample_stb (sample_v[g])
        );
    end

    assign tx_sck    = sck_v[0];
    assign tx_shift  = shift_v[0];
    assign tx_sample = sample_v[0];
    assign rx_sck    = sck_v[1];
    assign rx_shift  = shift_v[1];
    assign rx_sample = sample_v[1];

endmodule

// File: tb/serclk_divider_tb.sv
module serclk_divider_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic        rx_follow_tx = 1'b0;
    logic        clk_en = 1'b0;
    logic        cpol = 1'b0;
    logic        cpha = 1'b0;
    logic        tx_sck, tx_shift, tx_sample, rx_sck, rx_shift, rx_sample, cfg_err;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [15:0] tx_csr_m = '0;
    logic [15:0] rx_csr_m = '0;

    typedef struct {
        logic [5:0] v;
        string      tag;
        int         cyc;
    } item_t;
    item_t exp_q[$];

    always #5 clk = ~clk;

    serclk_divider u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .rx_follow_tx(rx_follow_tx), .clk_en(clk_en), .cpol(cpol), .cpha(cpha),
        .tx_sck(tx_sck), .tx_shift(tx_shift), .tx_sample(tx_sample),
        .rx_sck(rx_sck), .rx_shift(rx_shift), .rx_sample(rx_sample), .cfg_err(cfg_err)
    );

    // Divisor from the requirements (R2..R6).
    function automatic int exp_div(logic [15:0] csr);
        int p = int'(csr[12:8]) + 1;
        int r;
        case (csr[2:0])
            3'd0: r = 2;
            3'd1: r = 4;
            3'd2: r = 8;
            3'd3: r = 16;
            3'd4, 3'd5, 3'd6: r = 32;
            default: r = (p <= 2) ? 1 : 2;
        endcase
        return (p * r < 2) ? 2 : p * r;
    endfunction

    // {sck, shift, sample} at cycle j of an enabled window (R3, R9).
    function automatic logic [2:0] one_ch(int j, int n, logic pol, logic ph);
        int   m = j % n;
        logic s, ld, tr;
        s  = (m < n / 2) ? ~pol : pol;
        ld = (m == 0);
        tr = (m == n / 2);
        return {s, ph ? ld : tr, ph ? tr : ld};
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Monitor: compare every produced cycle against the scoreboard queue.
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            item_t e;
            logic [5:0] got;
            e = exp_q.pop_front();
            got = {tx_sck, tx_shift, tx_sample, rx_sck, rx_shift, rx_sample};
            n_chk++;
            if (got !== e.v) begin
                n_fail++;
                $display("FAIL %s cycle %0d: got %b expected %b", e.tag, e.cyc, got, e.v);
            end
        end
    end

    task automatic wr(logic sel, logic [15:0] d);
        @(negedge clk); #1;
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk); #1;
        cfg_we = 1'b0;
        if (sel) rx_csr_m = d;
        else     tx_csr_m = d;
    endtask

    // Driver: push the expected window, enable, then check the idle tail (R8).
    task automatic run_cmp(int len, string tag);
        int    ntx = exp_div(tx_csr_m);
        int    nrx = rx_follow_tx ? ntx : exp_div(rx_csr_m);
        item_t it;
        @(negedge clk); #1;
        for (int j = 0; j < len; j++) begin
            it.v   = {one_ch(j, ntx, cpol, cpha), one_ch(j, nrx, cpol, cpha)};
            it.tag = tag;
            it.cyc = j;
            exp_q.push_back(it);
        end
        clk_en = 1'b1;
        wait (exp_q.size() == 0);
        @(negedge clk); #1;
        clk_en = 1'b0;
        for (int j = 0; j < 3; j++) begin
            it.v   = {cpol, 2'b00, cpol, 2'b00};
            it.tag = "R8";
            it.cyc = j;
            exp_q.push_back(it);
        end
        wait (exp_q.size() == 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog (all requirements): got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk("R1", "tx_sck idle", tx_sck, 0);
        chk("R1", "strobes", {tx_shift, tx_sample, rx_shift, rx_sample}, 0);
        chk("R1", "cfg_err", cfg_err, 0);
        run_cmp(8, "R1");

        // R3/R9/R10: tx 3x4=12, cpol=1 cpha=1, rx follows tx although rx reg is 2.
        wr(1'b0, 16'h0201);
        cpol = 1'b1; cpha = 1'b1; rx_follow_tx = 1'b1;
        run_cmp(36, "R10");

        // R2/R3: rx 5x2=10 with stray bits set, independent of tx 12.
        wr(1'b1, 16'h0400 | 16'hE0F8);
        rx_follow_tx = 1'b0;
        run_cmp(60, "R2");

        // R4: reserved codes 5 and 6 act as ratio 32.
        cpol = 1'b0; cpha = 1'b0;
        wr(1'b0, 16'h0005);
        wr(1'b1, 16'h0106);
        run_cmp(128, "R4");

        // R5: ratio 1 legal with prescale 2; total 1 clamped to 2.
        wr(1'b0, 16'h0107);
        wr(1'b1, 16'h0007);
        @(negedge clk);
        chk("R5", "cfg_err after legal ratio 1", cfg_err, 0);
        run_cmp(8, "R5");

        // R6: ratio 1 with prescale 4 falls back to ratio 2 and flags.
        wr(1'b0, 16'h0307);
        @(negedge clk);
        chk("R6", "cfg_err after forbidden setting", cfg_err, 1);
        cpha = 1'b1;
        run_cmp(24, "R6");

        // R7: flag survives a legal write.
        wr(1'b0, 16'h0000);
        @(negedge clk);
        chk("R7", "cfg_err sticky", cfg_err, 1);

        // R11: largest divisor.
        wr(1'b0, 16'h1F04);
        cpha = 1'b0;
        run_cmp(2100, "R11");

        // R8: idle level follows cpol while disabled.
        @(negedge clk); #1 cpol = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R8", "tx_sck idle after cpol change", tx_sck, 1);
        chk("R8", "rx_sck idle after cpol change", rx_sck, 1);

        // R7: reset clears the flag.
        @(negedge clk); #1 rst = 1'b1;
        @(negedge clk); #1 rst = 1'b0;
        @(negedge clk);
        chk("R7", "cfg_err cleared by reset", cfg_err, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule